// File: doc/BRIEF.md
# Carrier Sense Hysteresis Qualifier

This block turns a raw, per-sample comparison of received signal strength against a carrier-sense threshold into a debounced carrier-sense flag. Each time the sample strobe is high, the block compares the signal-strength value with the threshold. A sample that equals the threshold counts as being on the high side.

The flag changes state only after an unbroken run of strobed samples on the opposite side of the threshold from its present state. The run needed to raise the flag is set by a 2-bit field and can be 1 to 4 samples. The run needed to drop the flag is set by a 1-bit field and can be 1 or 2 samples. A sample that lands back on the flag's own side starts the run over.

Both fields are static configuration inputs. Their usual setting of 1 asks for two samples in each direction. The output is registered and can drive a status pin directly.

Top module: `cs_carrier_qualifier`

## Requirements
- R1: The comparison is inclusive. A strobed sample with `rssiLevel >= csThreshold` counts as above the threshold, including `rssiLevel == csThreshold` at both ends of the range. A sample one count below the threshold counts as below.
- R2: While `csFlag` is 0, the flag goes to 1 once `setRunCfg + 1` consecutive strobed samples are at or above the threshold. The value of `setRunCfg` is read as an unsigned number from 0 to 3, so the run is 1 to 4 samples.
- R3: While `csFlag` is 1, the flag goes to 0 once `clrRunCfg + 1` consecutive strobed samples are below the threshold. A `clrRunCfg` of 0 means 1 sample and a value of 1 means 2 samples.
- R4: A strobed sample on the flag's own side of the threshold restarts the run. After such a sample, a full new run is needed before the flag changes.
- R5: On cycles where `sampleValid` is 0, both the flag and the run progress hold their values. A run therefore spans gaps between strobes.
- R6: When `rst` is high at a rising clock edge, the flag clears to 0 and the run restarts from zero. This is a synchronous reset.
- R7: `csFlag` is registered. It changes only at the rising edge that samples the strobe completing the run, and never before that edge.
- R8: If a run field changes during a run, the next strobe compares the run length so far, including that strobe, against the new target. If the run has already reached the new target, the flag changes on the next qualifying strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleValid | input | 1 | Sample strobe; a comparison is taken only when this is high |
| rssiLevel | input | LEVEL_W | Signal-strength sample |
| csThreshold | input | LEVEL_W | Carrier-sense threshold |
| setRunCfg | input | SET_W | Run length to raise the flag, minus one |
| clrRunCfg | input | CLR_W | Run length to drop the flag, minus one |
| csFlag | output | 1 | Qualified carrier-sense flag |

## Verification
The debouncer is driven with several kinds of sample streams:
- Uninterrupted runs at every set length and both clear lengths. These show that the run target is counted exactly, neither one short nor one long.
- Runs broken by a single sample on the wrong side. These show that a run restarts rather than resuming.
- Runs interleaved with idle cycles. These separate a run that counts only strobed samples from one that counts clock cycles.
- Samples exactly at the threshold and one count under it, at the middle and at the ends of the value range. These tell an inclusive comparison from a strict one.
- Field changes in the middle of a run, and a reset during a run. These show that an earlier, partial run is kept or dropped as required.

// File: rtl/cs_qual_pkg.sv
package cs_qual_pkg;

  // Actions the control asks the datapath to take on one strobe
  typedef struct packed {
    logic runAdvance;
    logic runClear;
    logic flagSet;
    logic flagClear;
  } csStrobes_t;

endpackage

// File: rtl/cs_qual_datapath.sv
module cs_qual_datapath
  import cs_qual_pkg::*;
#(
  parameter int LEVEL_W = 8,
  parameter int CNT_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LEVEL_W-1:0] rssiLevel,
  input  logic [LEVEL_W-1:0] csThreshold,
  input  csStrobes_t         strobes,
  output logic               atOrAbove,
  output logic [CNT_W-1:0]   runCount,
  output logic               csFlag
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  // Inclusive comparison: equal counts as above
  assign atOrAbove = (rssiLevel >= csThreshold);

  always_ff @(posedge clk) begin
    if (rst) begin
      runCount <= '0;
    end else if (strobes.runClear) begin
      runCount <= '0;
    end else if (strobes.runAdvance) begin
      runCount <= runCount + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csFlag <= 1'b0;
    end else if (strobes.flagSet) begin
      csFlag <= 1'b1;
    end else if (strobes.flagClear) begin
      csFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/cs_qual_control.sv
module cs_qual_control
  import cs_qual_pkg::*;
#(
  parameter int SET_W = 2,
  parameter int CLR_W = 1,
  parameter int CNT_W = 3
) (
  input  logic             sampleValid,
  input  logic             atOrAbove,
  input  logic [CNT_W-1:0] runCount,
  input  logic             csFlag,
  input  logic [SET_W-1:0] setRunCfg,
  input  logic [CLR_W-1:0] clrRunCfg,
  output csStrobes_t       strobes
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] setTarget;
  logic [CNT_W-1:0] clrTarget;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] nextRun;
  logic             opposite;

  assign setTarget = {{(CNT_W-SET_W){1'b0}}, setRunCfg} + ONE;
  assign clrTarget = {{(CNT_W-CLR_W){1'b0}}, clrRunCfg} + ONE;
  assign target    = csFlag ? clrTarget : setTarget;
  assign opposite  = csFlag ? ~atOrAbove : atOrAbove;
  assign nextRun   = runCount + ONE;

  always_comb begin
    strobes = '0;
    if (sampleValid) begin
      if (!opposite) begin
        strobes.runClear = 1'b1;
      end else if (nextRun >= target) begin
        strobes.runClear  = 1'b1;
        strobes.flagSet   = ~csFlag;
        strobes.flagClear = csFlag;
      end else begin
        strobes.runAdvance = 1'b1;
      end
    end
  end

endmodule

// File: rtl/cs_carrier_qualifier.sv
module cs_carrier_qualifier
  import cs_qual_pkg::*;
#(
  parameter int LEVEL_W = 8,
  parameter int SET_W   = 2,
  parameter int CLR_W   = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sampleValid,
  input  logic [LEVEL_W-1:0] rssiLevel,
  input  logic [LEVEL_W-1:0] csThreshold,
  input  logic [SET_W-1:0]   setRunCfg,
  input  logic [CLR_W-1:0]   clrRunCfg,
  output logic               csFlag
);

  localparam int SET_MAX = 1 << SET_W;
  localparam int CLR_MAX = 1 << CLR_W;
  localparam int RUN_MAX = (SET_MAX > CLR_MAX) ? SET_MAX : CLR_MAX;
  localparam int CNT_W   = $clog2(RUN_MAX + 1);

  csStrobes_t       strobes;
  logic             atOrAbove;
  logic [CNT_W-1:0] runCount;

  cs_qual_control #(.SET_W(SET_W), .CLR_W(CLR_W), .CNT_W(CNT_W)) u_ctrl (
    .sampleValid(sampleValid),
    .atOrAbove  (atOrAbove),
    .runCount   (runCount),
    .csFlag     (csFlag),
    .setRunCfg  (setRunCfg),
    .clrRunCfg  (clrRunCfg),
    .strobes    (strobes)
  );

  cs_qual_datapath #(.LEVEL_W(LEVEL_W), .CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .rssiLevel  (rssiLevel),
    .csThreshold(csThreshold),
    .strobes    (strobes),
    .atOrAbove  (atOrAbove),
    .runCount   (runCount),
    .csFlag     (csFlag)
  );

endmodule

// File: rtl/cs_qual_checker.sv
module cs_qual_checker #(
  parameter int LEVEL_W = 8,
  parameter int SET_W   = 2,
  parameter int CLR_W   = 1,
  parameter int CNT_W   = 3,
  parameter int RUN_MAX = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               sampleValid,
  input logic [LEVEL_W-1:0] rssiLevel,
  input logic [LEVEL_W-1:0] csThreshold,
  input logic [SET_W-1:0]   setRunCfg,
  input logic [CLR_W-1:0]   clrRunCfg,
  input logic               csFlag,
  input logic [CNT_W-1:0]   runCount
);

  AST_EQUAL_QUALIFIES: assert property (@(posedge clk) disable iff (rst)
    (sampleValid && rssiLevel == csThreshold && !csFlag && setRunCfg == '0) |=> csFlag); // R1

  AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(csFlag) |-> $past(sampleValid && (rssiLevel >= csThreshold))); // R2

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
    (int'(runCount) < RUN_MAX)); // R2

  AST_FALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    ($fell(csFlag) && !$past(rst)) |-> $past(sampleValid && (rssiLevel < csThreshold))); // R3

  AST_SINGLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (sampleValid && rssiLevel < csThreshold && csFlag && clrRunCfg == '0) |=> !csFlag); // R3

  AST_RESTART_RUN: assert property (@(posedge clk) disable iff (rst)
    (sampleValid && !csFlag && rssiLevel < csThreshold) |=> (runCount == '0)); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !sampleValid |=> ($stable(csFlag) && $stable(runCount))); // R5

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!csFlag && runCount == '0)); // R6

endmodule

bind cs_carrier_qualifier cs_qual_checker #(
  .LEVEL_W(LEVEL_W), .SET_W(SET_W), .CLR_W(CLR_W), .CNT_W(CNT_W), .RUN_MAX(RUN_MAX)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sampleValid(sampleValid),
  .rssiLevel  (rssiLevel),
  .csThreshold(csThreshold),
  .setRunCfg  (setRunCfg),
  .clrRunCfg  (clrRunCfg),
  .csFlag     (csFlag),
  .runCount   (runCount)
);

// File: tb/tb_cs_carrier_qualifier.sv
module tb_cs_carrier_qualifier;

  logic       clk = 1'b0;
  logic       rst;
  logic       sampleValid;
  logic [7:0] rssiLevel;
  logic [7:0] csThreshold;
  logic [1:0] setRunCfg;
  logic [0:0] clrRunCfg;
  logic       csFlag;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  cs_carrier_qualifier dut (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .rssiLevel(rssiLevel),
    .csThreshold(csThreshold), .setRunCfg(setRunCfg), .clrRunCfg(clrRunCfg),
    .csFlag(csFlag)
  );

  // Layout: [20] strobe, [19:12] level, [11:4] threshold, [3:2] set field, [1] clear field, [0] expected flag
  localparam int NV = 28;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 8'd120, 8'd100, 2'd1, 1'b1, 1'b0},  // R2 first of two
    {1'b1, 8'd100, 8'd100, 2'd1, 1'b1, 1'b1},  // R1 equal completes run
    {1'b0, 8'd0,   8'd100, 2'd1, 1'b1, 1'b1},  // R5 idle holds
    {1'b1, 8'd50,  8'd100, 2'd1, 1'b1, 1'b1},  // R3 first below
    {1'b1, 8'd150, 8'd100, 2'd1, 1'b1, 1'b1},  // R4 restart
    {1'b1, 8'd50,  8'd100, 2'd1, 1'b1, 1'b1},  // R4 new run 1
    {1'b0, 8'd50,  8'd100, 2'd1, 1'b1, 1'b1},  // R5 gap
    {1'b1, 8'd50,  8'd100, 2'd1, 1'b1, 1'b0},  // R3 run spans gap
    {1'b1, 8'd99,  8'd100, 2'd1, 1'b1, 1'b0},  // R1 one under
    {1'b1, 8'd200, 8'd100, 2'd3, 1'b1, 1'b0},  // R2 set=3 run 1
    {1'b1, 8'd200, 8'd100, 2'd3, 1'b1, 1'b0},  // R2 run 2
    {1'b1, 8'd10,  8'd100, 2'd3, 1'b1, 1'b0},  // R4 restart
    {1'b1, 8'd200, 8'd100, 2'd3, 1'b1, 1'b0},  // R2 run 1
    {1'b1, 8'd200, 8'd100, 2'd3, 1'b1, 1'b0},  // R2 run 2
    {1'b1, 8'd200, 8'd100, 2'd3, 1'b1, 1'b0},  // R2 run 3
    {1'b1, 8'd200, 8'd100, 2'd3, 1'b1, 1'b1},  // R2 run 4 sets
    {1'b1, 8'd10,  8'd100, 2'd3, 1'b0, 1'b0},  // R3 clear=0 single
    {1'b1, 8'd200, 8'd100, 2'd0, 1'b0, 1'b1},  // R2 set=0 single
    {1'b1, 8'd10,  8'd100, 2'd0, 1'b1, 1'b1},  // R3 run 1
    {1'b1, 8'd10,  8'd100, 2'd0, 1'b1, 1'b0},  // R3 run 2 clears
    {1'b1, 8'd200, 8'd100, 2'd3, 1'b1, 1'b0},  // R8 run 1
    {1'b1, 8'd200, 8'd100, 2'd3, 1'b1, 1'b0},  // R8 run 2
    {1'b1, 8'd200, 8'd100, 2'd1, 1'b1, 1'b1},  // R8 lowered target
    {1'b1, 8'd10,  8'd100, 2'd1, 1'b1, 1'b1},  // R8 run 1
    {1'b1, 8'd10,  8'd100, 2'd1, 1'b0, 1'b0},  // R8 lowered clear target
    {1'b1, 8'd0,   8'd0,   2'd0, 1'b0, 1'b1},  // R1 zero equals zero
    {1'b1, 8'd255, 8'd255, 2'd0, 1'b0, 1'b1},  // R1 top equal stays high
    {1'b1, 8'd254, 8'd255, 2'd0, 1'b0, 1'b0}   // R1 one under top
  };

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: csFlag=%0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [7:0] lvl, input logic [7:0] thr,
                       input logic [1:0] s, input logic c);
    sampleValid = v; rssiLevel = lvl; csThreshold = thr; setRunCfg = s; clrRunCfg = c;
  endtask

  task automatic step_check(input logic exp, input string tag);
    @(posedge clk); #1;
    check(csFlag, exp, tag);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: csFlag=%0b expected completion", csFlag);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1;
    drive(1'b0, 8'd0, 8'd100, 2'd1, 1'b1);
    repeat (3) @(negedge clk);
    check(csFlag, 1'b0, "R6 reset state");
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][20], VEC[i][19:12], VEC[i][11:4], VEC[i][3:2], VEC[i][1]);
      step_check(VEC[i][0], $sformatf("vector %0d", i));
    end

    // R6: reset during a partial run discards it
    drive(1'b1, 8'd200, 8'd100, 2'd1, 1'b1);
    step_check(1'b0, "R6 run before reset");
    drive(1'b0, 8'd200, 8'd100, 2'd1, 1'b1);
    rst = 1'b1;
    step_check(1'b0, "R6 in reset");
    rst = 1'b0;
    drive(1'b1, 8'd200, 8'd100, 2'd1, 1'b1);
    step_check(1'b0, "R6 run restarted");
    step_check(1'b1, "R2 run completes after reset");

    // R6: reset clears an asserted flag
    drive(1'b0, 8'd200, 8'd100, 2'd1, 1'b1);
    rst = 1'b1;
    step_check(1'b0, "R6 clears asserted flag");
    rst = 1'b0;

    // R7: output changes only at the edge
    drive(1'b1, 8'd200, 8'd100, 2'd0, 1'b0);
    #1 check(csFlag, 1'b0, "R7 before edge set");
    step_check(1'b1, "R7 after edge set");
    drive(1'b1, 8'd20, 8'd100, 2'd0, 1'b0);
    #1 check(csFlag, 1'b1, "R7 before edge clear");
    step_check(1'b0, "R7 after edge clear");

    // R5: many idle cycles with above-threshold level do not set
    drive(1'b0, 8'd250, 8'd100, 2'd0, 1'b0);
    repeat (5) @(posedge clk);
    #1 check(csFlag, 1'b0, "R5 long idle");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule